// File: doc/BRIEF.md
# ISA Interrupt Aggregator Register Block

This block collects eight ISA interrupt request lines into one packed pending register and presents them to a host processor over a 16-bit memory-mapped slave interface. Each line passes through a synchronizer. Each rising edge on a line sets its own pending bit. The host reads the pending register, services the lowest set bit first, and acknowledges by writing a mask in which every set bit clears the matching pending bit. A single combined interrupt line tells the host that work is waiting. The host samples that line on its rising edge, so the line falls once the last pending bit is cleared and rises again when a later request arrives.

The interface decodes four registers over a 32 MB chip-select window, using only the two top address bits. The four registers are a fixed version/issue word, the pending/acknowledge register, a control register whose bit 0 drives a CompactFlash reset output, and a read/write slot kept for an external watchdog.

The combined line comes from a two-state machine. The state `IRQ_QUIET` moves to `IRQ_RAISED` when any pending bit is set (transition *raise*). The state `IRQ_RAISED` moves back to `IRQ_QUIET` when the pending register is empty (transition *drop*). In every other case the state holds.

Top module: `isa_irq_aggregator`

## Requirements
- R1: Input bit `isa_irq[i]` feeds pending bit i. The bit order is ISA IRQ 3,4,5,6,7,10,11,12 on bits 0..7. A rising edge on an input sets its pending bit three clock edges after the input changes (two synchronizer stages, then the pending flop).
- R2: Only rising edges set pending bits. An input held high sets its bit once, and after that bit is acknowledged it stays clear while the input remains high.
- R3: A read with address bits [24:23] = 2'b01 returns the pending bits in read-data bits [7:0], with bits [15:8] zero.
- R4: A write with address bits [24:23] = 2'b01 clears exactly the pending bits whose write-data bit is 1. All other bits are kept, and a zero mask changes nothing.
- R5: When a new rising edge and an acknowledge reach the same bit in the same cycle, the bit ends up set.
- R6: `host_irq` is 1 exactly one cycle after any pending bit is 1, and 0 one cycle after all pending bits are 0. It therefore rises again when a new request arrives after a full acknowledge.
- R7: A read with address bits [24:23] = 2'b00 returns {8'h00, VER_MAJOR[3:0], VER_ISSUE[3:0]}, and writes to that address change nothing.
- R8: Address bits [24:23] = 2'b10 select an 8-bit control register. Writes store write-data bits [7:0], reads return them with bits [15:8] zero, and `cf_reset` follows control bit 0 from the cycle after the write.
- R9: Address bits [24:23] = 2'b11 select a 16-bit watchdog slot that stores and returns whatever is written.
- R10: Address bits [22:0] are ignored, so each register repeats over its whole 8 MB quarter of the window.
- R11: Reset clears the pending bits, the control register, the watchdog slot, `host_irq` and `cf_reset`.
- R12: `bus_rdata` is zero whenever no read is in progress (`bus_sel` low or `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| isa_irq | input | 8 | ISA request lines, bit 0 = IRQ3 ... bit 7 = IRQ12 |
| bus_sel | input | 1 | Access strobe for this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 25 | Byte address within the 32 MB window |
| bus_wdata | input | 16 | Halfword write data |
| bus_rdata | output | 16 | Halfword read data, combinational |
| host_irq | output | 1 | Combined interrupt to the host |
| cf_reset | output | 1 | CompactFlash reset, control bit 0 |

## Verification
The set path from a synchronized rising edge and the clear path from an acknowledge write can hit the same pending bit in the same clock. The bench provokes this by placing the acknowledge write in exactly the cycle in which the edge detector fires. That is the second edge after the input rises. In the same write the bench also clears a second bit that has no edge. It then judges the outcome by reading back the pending register: the colliding bit must still be set and the other bit must be cleared. A second overlap is the acknowledge of the last pending bit against the one-cycle lag of the combined line. The bench checks that line on both sides of that edge.

// File: rtl/isairq_pkg.sv
package isairq_pkg;

    localparam int BUS_W = 16;

    typedef enum logic [1:0] {
        REG_VERSION = 2'd0,
        REG_IRQ     = 2'd1,
        REG_CTRL    = 2'd2,
        REG_WDOG    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } line_state_e;

endpackage

// File: rtl/isairq_edge_sync.sv
module isairq_edge_sync #(
    parameter int NUM_IRQ     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] lines_in,
    output logic [NUM_IRQ-1:0] rise
);
    logic [NUM_IRQ-1:0] chain [SYNC_STAGES];
    logic [NUM_IRQ-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) chain[s] <= '0;
            prev_q <= '0;
        end else begin
            chain[0] <= lines_in;
            for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
            prev_q <= chain[SYNC_STAGES-1];
        end
    end

    assign rise = chain[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/isairq_pending.sv
module isairq_pending #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] rise,
    input  logic [NUM_IRQ-1:0] ack_mask,
    output logic [NUM_IRQ-1:0] pend_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~ack_mask) | rise;
    end
endmodule

// File: rtl/isairq_line_fsm.sv
module isairq_line_fsm
    import isairq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pending,
    output logic host_irq
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_pending)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_pending) state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        host_irq = 1'b0;
        unique case (state_q)
            IRQ_QUIET:  host_irq = 1'b0;
            IRQ_RAISED: host_irq = 1'b1;
        endcase
    end
endmodule

// File: rtl/isa_irq_aggregator.sv
module isa_irq_aggregator
    import isairq_pkg::*;
#(
    parameter int         ADDR_W      = 25,
    parameter int         NUM_IRQ     = 8,
    parameter int         CTRL_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] VER_MAJOR   = 4'h2,
    parameter logic [3:0] VER_ISSUE   = 4'h5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] isa_irq,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               host_irq,
    output logic               cf_reset
);
    localparam int SEL_LSB = ADDR_W - 2;

    reg_sel_e           reg_sel;
    logic               wr_en, rd_en;
    logic [NUM_IRQ-1:0] rise_vec, ack_mask, pend_q;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [BUS_W-1:0]   wdog_q;

    assign reg_sel = reg_sel_e'(bus_addr[ADDR_W-1:SEL_LSB]);
    assign wr_en   = bus_sel & bus_wr;
    assign rd_en   = bus_sel & ~bus_wr;
    assign ack_mask = (wr_en && reg_sel == REG_IRQ) ? bus_wdata[NUM_IRQ-1:0] : '0;

    isairq_edge_sync #(.NUM_IRQ(NUM_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .lines_in(isa_irq), .rise(rise_vec)
    );

    isairq_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk(clk), .rst_n(rst_n), .rise(rise_vec), .ack_mask(ack_mask), .pend_q(pend_q)
    );

    isairq_line_fsm u_line (
        .clk(clk), .rst_n(rst_n), .any_pending(|pend_q), .host_irq(host_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            wdog_q <= '0;
        end else if (wr_en) begin
            if (reg_sel == REG_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (reg_sel == REG_WDOG) wdog_q <= bus_wdata;
        end
    end

    assign cf_reset = ctrl_q[0];

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (reg_sel)
                REG_VERSION: bus_rdata = {{(BUS_W-8){1'b0}}, VER_MAJOR, VER_ISSUE};
                REG_IRQ:     bus_rdata = {{(BUS_W-NUM_IRQ){1'b0}}, pend_q};
                REG_CTRL:    bus_rdata = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
                REG_WDOG:    bus_rdata = wdog_q;
            endcase
        end
    end
endmodule

// File: rtl/isa_irq_aggregator_chk.sv
module isa_irq_aggregator_chk
    import isairq_pkg::*;
#(
    parameter int         ADDR_W    = 25,
    parameter int         NUM_IRQ   = 8,
    parameter logic [3:0] VER_MAJOR = 4'h2,
    parameter logic [3:0] VER_ISSUE = 4'h5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [BUS_W-1:0]   bus_wdata,
    input logic [BUS_W-1:0]   bus_rdata,
    input logic               host_irq,
    input logic               cf_reset,
    input logic [NUM_IRQ-1:0] pend_q,
    input logic [NUM_IRQ-1:0] rise_vec
);
    logic [1:0] top;
    logic       rd, wr;
    assign top = bus_addr[ADDR_W-1:ADDR_W-2];
    assign rd  = bus_sel & ~bus_wr;
    assign wr  = bus_sel & bus_wr;

    a_r6_line_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_q) |=> host_irq);

    a_r6_line_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |=> !host_irq);

    a_r1_set_only_by_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise_vec)) == '0));

    a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_vec) |=> ((pend_q & $past(rise_vec)) == $past(rise_vec)));

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && top == 2'd1) |=> ((pend_q & $past(bus_wdata[NUM_IRQ-1:0] & ~rise_vec)) == '0));

    a_r8_cf_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && top == 2'd2) |=> (cf_reset == $past(bus_wdata[0])));

    a_r7_version: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && top == 2'd0) |-> (bus_rdata == {8'h00, VER_MAJOR, VER_ISSUE}));

    a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (bus_rdata == '0));

    a_r10_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && $past(rd) && top != 2'd1 && top == $past(top) && bus_addr != $past(bus_addr))
        |-> $stable(bus_rdata));
endmodule

bind isa_irq_aggregator isa_irq_aggregator_chk #(
    .ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ), .VER_MAJOR(VER_MAJOR), .VER_ISSUE(VER_ISSUE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq), .cf_reset(cf_reset),
    .pend_q(pend_q), .rise_vec(rise_vec)
);

// File: tb/test_isa_irq_aggregator.sv
module test_isa_irq_aggregator;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  isa_irq = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [24:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        host_irq;
    logic        cf_reset;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isa_irq_aggregator i_isa_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .isa_irq(isa_irq), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_irq(host_irq), .cf_reset(cf_reset)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] rsel, logic [22:0] low, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {rsel, low}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [1:0] rsel, logic [22:0] low, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {rsel, low};
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic raise(logic [7:0] m);
        @(negedge clk); isa_irq = isa_irq | m;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lower(logic [7:0] m);
        @(negedge clk); isa_irq = isa_irq & ~m;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R11 host_irq", {15'd0, host_irq}, 16'd0);
        check("R11 cf_reset", {15'd0, cf_reset}, 16'd0);
        bus_read(2'd1, 23'd0, d); check("R11 pending", d, 16'h0000);
        bus_read(2'd2, 23'd0, d); check("R11 control", d, 16'h0000);
        bus_read(2'd3, 23'd0, d); check("R11 watchdog", d, 16'h0000);
        #1 check("R12 idle rdata", bus_rdata, 16'h0000);
    endtask

    task automatic t_version();
        logic [15:0] d;
        bus_read(2'd0, 23'd0, d); check("R7 version", d, 16'h0025);
        bus_write(2'd0, 23'd0, 16'hFFFF);
        bus_read(2'd0, 23'd0, d); check("R7 version after write", d, 16'h0025);
    endtask

    task automatic t_mapping();
        logic [15:0] d;
        for (int i = 0; i < 8; i++) begin
            raise(8'(1 << i));
            bus_read(2'd1, 23'd0, d); check("R1 R3 line to bit", d, 16'(1 << i));
            check("R6 host_irq set", {15'd0, host_irq}, 16'd1);
            bus_write(2'd1, 23'd0, 16'(1 << i));
            bus_read(2'd1, 23'd0, d); check("R4 single ack", d, 16'h0000);
            lower(8'(1 << i));
        end
    endtask

    task automatic t_level();
        logic [15:0] d;
        raise(8'h04);
        bus_write(2'd1, 23'd0, 16'h0004);
        repeat (5) @(negedge clk);
        bus_read(2'd1, 23'd0, d); check("R2 held level no reset", d, 16'h0000);
        lower(8'h04);
    endtask

    task automatic t_partial_ack();
        logic [15:0] d;
        raise(8'hA9);
        bus_read(2'd1, 23'd0, d); check("R3 multi pending", d, 16'h00A9);
        bus_write(2'd1, 23'd0, 16'hFF21);
        bus_read(2'd1, 23'd0, d); check("R4 partial ack", d, 16'h0088);
        bus_write(2'd1, 23'd0, 16'h0000);
        bus_read(2'd1, 23'd0, d); check("R4 zero mask", d, 16'h0088);
        check("R6 still raised", {15'd0, host_irq}, 16'd1);
        bus_write(2'd1, 23'd0, 16'h0088);
        @(negedge clk);
        check("R6 dropped", {15'd0, host_irq}, 16'd0);
        lower(8'hA9);
    endtask

    task automatic t_line_timing();
        logic [15:0] d;
        @(negedge clk); isa_irq[6] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        bus_read(2'd1, 23'd0, d); check("R1 third edge", d, 16'h0040);
        check("R6 lag before", {15'd0, host_irq}, 16'd0);
        @(negedge clk);
        check("R6 raised after one", {15'd0, host_irq}, 16'd1);
        bus_write(2'd1, 23'd0, 16'h0040);
        check("R6 still high at clear edge", {15'd0, host_irq}, 16'd1);
        @(negedge clk);
        check("R6 low after clear", {15'd0, host_irq}, 16'd0);
        raise(8'h02);
        check("R6 fresh rise", {15'd0, host_irq}, 16'd1);
        bus_write(2'd1, 23'd0, 16'h0002);
        lower(8'h42);
    endtask

    task automatic t_collision();
        logic [15:0] d;
        raise(8'h11);
        lower(8'h11);
        bus_read(2'd1, 23'd0, d); check("R1 setup collision", d, 16'h0011);
        isa_irq[4] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {2'd1, 23'd0}; bus_wdata = 16'h0011;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        bus_read(2'd1, 23'd0, d); check("R5 edge wins", d, 16'h0010);
        bus_write(2'd1, 23'd0, 16'h0010);
        lower(8'h10);
    endtask

    task automatic t_ctrl();
        logic [15:0] d;
        bus_write(2'd2, 23'd0, 16'h005A);
        bus_read(2'd2, 23'd0, d); check("R8 ctrl readback", d, 16'h005A);
        check("R8 cf_reset low", {15'd0, cf_reset}, 16'd0);
        bus_write(2'd2, 23'd0, 16'hFF03);
        bus_read(2'd2, 23'd0, d); check("R8 ctrl width", d, 16'h0003);
        check("R8 cf_reset high", {15'd0, cf_reset}, 16'd1);
    endtask

    task automatic t_wdog();
        logic [15:0] d;
        bus_write(2'd3, 23'd0, 16'hBEEF);
        bus_read(2'd3, 23'd0, d); check("R9 watchdog slot", d, 16'hBEEF);
    endtask

    task automatic t_alias();
        logic [15:0] d;
        bus_write(2'd2, 23'h7FFFFE, 16'h0040);
        bus_read(2'd2, 23'h000123, d); check("R10 ctrl alias", d, 16'h0040);
        check("R10 cf_reset via alias", {15'd0, cf_reset}, 16'd0);
        bus_read(2'd0, 23'h400000, d); check("R10 version alias", d, 16'h0025);
        bus_read(2'd3, 23'h000002, d); check("R10 wdog alias", d, 16'hBEEF);
    endtask

    task automatic t_idle_zero();
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {2'd3, 23'd0}; bus_wdata = 16'hBEEF;
        #1 check("R12 zero during write", bus_rdata, 16'h0000);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = {2'd3, 23'd0};
        #1 check("R12 zero when unselected", bus_rdata, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_version();
        t_mapping();
        t_level();
        t_partial_ack();
        t_line_timing();
        t_collision();
        t_ctrl();
        t_wdog();
        t_alias();
        t_idle_zero();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule